// File: doc/BRIEF.md
# ROM Overlay Memory-Map Decoder

This block routes CPU word addresses from three masters: a program bus, a data bus and a DMA bus. Each address goes either to one of four on-chip ROM banks or to the external memory space. For an external access the block gives the chip-select index of the region. A one-bit overlay mode register, written by software, decides what the top 64K-word window means. When the bit is clear the window is ROM. When the bit is set the ROM leaves the map and the window becomes part of the top external chip-select region.

Address decoding is combinational, so a request appears in the same cycle as its address. Only the overlay bit is stored. A hardware reset clears the overlay bit. A software reset does not change it. The DMA master can never reach the ROM. A DMA access that lands in the mapped ROM window is refused with an error flag. The program bus and the data bus may hit the same bank in the same cycle. In that case the program bus is served and the data bus is held for the cycle.

Top module: `rom_overlay_decoder`

## Requirements
- R1: With the overlay bit at 0, a program or data access to word addresses 7F_0000h–7F_FFFFh raises that bus's ROM grant. The bank index is address bits [15:14] and the bank offset is bits [13:0]. No external request is raised.
- R2: With the overlay bit at 1, any access in the window raises no ROM grant. It raises an external request with chip-select index 5 instead.
- R3: While `hw_rst_n` is low the overlay bit reads 0 on `ovl_q`, even if a write is attempted. After release, a window access is a ROM access until software writes a 1.
- R4: While `sw_rst` is high the overlay bit keeps its value and writes are ignored. All grant, request, stall and error outputs of the three buses are held low.
- R5: With `ovl_we` high and `sw_rst` low at a rising clock edge, the overlay bit takes `ovl_wdata`. The new value shows on `ovl_q` and in the decode from the next cycle.
- R6: A DMA access in the window never selects a ROM bank. With the overlay bit at 0 it raises `m_err` and no external request. With the overlay bit at 1 it raises `m_ext` with index 5.
- R7: When the program and data buses are both granted ROM in the same bank, the program bus keeps its grant. `d_rom` is low and `d_stall` is high. When the two banks differ, both grants are high and `d_stall` is low.
- R8: External chip-select index by word address:
  - 02_8000h–1F_FFFFh gives 0.
  - 20_0000h–3F_FFFFh gives 1.
  - 40_0000h–5F_FFFFh gives 2.
  - 60_0000h–6F_FFFFh gives 3.
  - 70_0000h–77_FFFFh gives 4.
  - 78_0000h–7F_FFFFh gives 5.
- R9: Word addresses below 02_8000h raise no grant, no external request and no error on any bus.
- R10: Bit b of `bank_en` is high exactly when a granted program or data access targets bank b in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Hardware reset, asynchronous, active low |
| sw_rst | input | 1 | Software reset, synchronous, active high |
| ovl_we | input | 1 | Overlay bit write enable |
| ovl_wdata | input | 1 | Overlay bit write value |
| ovl_q | output | 1 | Current overlay bit |
| p_valid | input | 1 | Program bus access valid |
| p_addr | input | 23 | Program bus word address |
| d_valid | input | 1 | Data bus access valid |
| d_addr | input | 23 | Data bus word address |
| m_valid | input | 1 | DMA bus access valid |
| m_addr | input | 23 | DMA bus word address |
| p_rom | output | 1 | Program ROM grant |
| p_bank | output | 2 | Program ROM bank index |
| p_off | output | 14 | Program bank word offset |
| p_ext | output | 1 | Program external request |
| p_cs | output | 3 | Program chip-select index |
| d_rom | output | 1 | Data ROM grant |
| d_stall | output | 1 | Data bus held by a bank conflict |
| d_bank | output | 2 | Data ROM bank index |
| d_off | output | 14 | Data bank word offset |
| d_ext | output | 1 | Data external request |
| d_cs | output | 3 | Data chip-select index |
| m_ext | output | 1 | DMA external request |
| m_cs | output | 3 | DMA chip-select index |
| m_err | output | 1 | DMA access to mapped ROM refused |
| bank_en | output | 4 | Per-bank enable for granted accesses |

## Verification
The only state in the block is the overlay bit, so any error in it shows up at the ports. The first window access after the fault would be steered wrongly, in the same cycle it is presented. It would show as a ROM grant where chip select 5 was due, or as a DMA error where an external request was due. The bench writes the bit, pulses both reset types and then issues window accesses at once. A retention or clearing fault is therefore caught within one cycle. Bank conflicts are forced with directed same-bank and different-bank pairs and also arise in random traffic.

// File: rtl/rom_overlay_decoder.sv
module rom_overlay_decoder #(
  parameter int AW     = 23,
  parameter int OFF_W  = 14,
  parameter int BANK_W = 2,
  parameter logic [AW-1:0] WIN_BASE = 23'h7F0000,
  parameter logic [AW-1:0] EXT_BASE = 23'h028000
) (
  input  logic              clk,
  input  logic              hw_rst_n,
  input  logic              sw_rst,
  input  logic              ovl_we,
  input  logic              ovl_wdata,
  output logic              ovl_q,
  input  logic              p_valid,
  input  logic [AW-1:0]     p_addr,
  input  logic              d_valid,
  input  logic [AW-1:0]     d_addr,
  input  logic              m_valid,
  input  logic [AW-1:0]     m_addr,
  output logic              p_rom,
  output logic [BANK_W-1:0] p_bank,
  output logic [OFF_W-1:0]  p_off,
  output logic              p_ext,
  output logic [2:0]        p_cs,
  output logic              d_rom,
  output logic              d_stall,
  output logic [BANK_W-1:0] d_bank,
  output logic [OFF_W-1:0]  d_off,
  output logic              d_ext,
  output logic [2:0]        d_cs,
  output logic              m_ext,
  output logic [2:0]        m_cs,
  output logic              m_err,
  output logic [(1<<BANK_W)-1:0] bank_en
);
  localparam int TAG_LSB = OFF_W + BANK_W;
  localparam int NBANK   = 1 << BANK_W;

  function automatic logic in_win(input logic [AW-1:0] a);
    return a[AW-1:TAG_LSB] == WIN_BASE[AW-1:TAG_LSB];
  endfunction

  function automatic logic [2:0] cs_of(input logic [AW-1:0] a);
    if (a[AW-1:AW-2] != 2'b11) return {1'b0, a[AW-1:AW-2]};
    else if (!a[AW-3])         return 3'd3;
    else if (!a[AW-4])         return 3'd4;
    else                       return 3'd5;
  endfunction

  always_ff @(posedge clk or negedge hw_rst_n)
    if (!hw_rst_n)              ovl_q <= 1'b0;
    else if (ovl_we && !sw_rst) ovl_q <= ovl_wdata;

  logic p_go, d_go, m_go, p_hit, d_hit, m_hit;
  assign p_go  = p_valid && !sw_rst;
  assign d_go  = d_valid && !sw_rst;
  assign m_go  = m_valid && !sw_rst;
  assign p_hit = p_go && in_win(p_addr) && !ovl_q;
  assign d_hit = d_go && in_win(d_addr) && !ovl_q;
  assign m_hit = m_go && in_win(m_addr) && !ovl_q;

  assign p_bank = p_addr[TAG_LSB-1:OFF_W];
  assign d_bank = d_addr[TAG_LSB-1:OFF_W];
  assign p_off  = p_addr[OFF_W-1:0];
  assign d_off  = d_addr[OFF_W-1:0];
  assign p_cs   = cs_of(p_addr);
  assign d_cs   = cs_of(d_addr);
  assign m_cs   = cs_of(m_addr);

  assign p_rom   = p_hit;
  assign d_stall = d_hit && p_hit && (p_bank == d_bank);
  assign d_rom   = d_hit && !d_stall;
  assign m_err   = m_hit;

  assign p_ext = p_go && (p_addr >= EXT_BASE) && !p_hit;
  assign d_ext = d_go && (d_addr >= EXT_BASE) && !d_hit;
  assign m_ext = m_go && (m_addr >= EXT_BASE) && !m_hit;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    assign bank_en[g] = (p_rom && p_bank == BANK_W'(g)) || (d_rom && d_bank == BANK_W'(g));
  end

  // R5
  ovl_write_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (ovl_we && !sw_rst) |=> ovl_q == $past(ovl_wdata));
  // R4
  sw_keep_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
    sw_rst |=> $stable(ovl_q));
  // R4
  sw_quiet_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
    sw_rst |-> !(p_rom || d_rom || p_ext || d_ext || m_ext || m_err || d_stall));
  // R6
  dma_err_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
    m_err |-> !ovl_q && !m_ext);
  // R7
  stall_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
    d_stall |-> p_rom && !d_rom && !d_ext && (bank_en == NBANK'(1) << p_bank));
  // R10
  bank_cnt_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
    $countones(bank_en) == int'(p_rom) + int'(d_rom));
  // R2
  unmap_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
    ovl_q |-> !p_rom && !d_rom && bank_en == '0);
endmodule

// File: tb/test_rom_overlay_decoder.sv
module test_rom_overlay_decoder;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic hw_rst_n = 0, sw_rst = 0, ovl_we = 0, ovl_wdata = 0;
  logic p_valid = 0, d_valid = 0, m_valid = 0;
  logic [22:0] p_addr = 0, d_addr = 0, m_addr = 0;
  logic ovl_q, p_rom, p_ext, d_rom, d_stall, d_ext, m_ext, m_err;
  logic [1:0] p_bank, d_bank;
  logic [13:0] p_off, d_off;
  logic [2:0] p_cs, d_cs, m_cs;
  logic [3:0] bank_en;

  rom_overlay_decoder i_rom_overlay_decoder (.*);

  int checks = 0, errors = 0;
  logic md = 0;
  bit done = 0;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  function automatic logic win(logic [22:0] a); return a >= 23'h7F0000; endfunction

  // R8
  function automatic logic [2:0] exp_cs(logic [22:0] a);
    if (a < 23'h200000) return 0;
    if (a < 23'h400000) return 1;
    if (a < 23'h600000) return 2;
    if (a < 23'h700000) return 3;
    if (a < 23'h780000) return 4;
    return 5;
  endfunction

  task automatic step(logic pv, logic [22:0] pa, logic dv, logic [22:0] da,
                      logic mv, logic [22:0] ma, logic we, logic wd, logic sr);
    logic pr, dh, dr, ds, pe, de, me, merr;
    logic [3:0] be;
    @(negedge clk);
    p_valid = pv; p_addr = pa; d_valid = dv; d_addr = da; m_valid = mv; m_addr = ma;
    ovl_we = we; ovl_wdata = wd; sw_rst = sr;
    #1;
    pr   = pv && !sr && win(pa) && !md;
    dh   = dv && !sr && win(da) && !md;
    ds   = pr && dh && (pa[15:14] == da[15:14]);
    dr   = dh && !ds;
    merr = mv && !sr && win(ma) && !md;
    pe   = pv && !sr && pa >= 23'h028000 && !pr;
    de   = dv && !sr && da >= 23'h028000 && !dh;
    me   = mv && !sr && ma >= 23'h028000 && !merr;
    be   = 4'b0;
    if (pr) be[pa[15:14]] = 1'b1;
    if (dr) be[da[15:14]] = 1'b1;
    chk("R1 p_rom", 32'(p_rom), 32'(pr));
    chk("R7 d_rom", 32'(d_rom), 32'(dr));
    chk("R7 d_stall", 32'(d_stall), 32'(ds));
    chk("R2 p_ext", 32'(p_ext), 32'(pe));
    chk("R2 d_ext", 32'(d_ext), 32'(de));
    chk("R6 m_ext", 32'(m_ext), 32'(me));
    chk("R6 m_err", 32'(m_err), 32'(merr));
    chk("R10 bank_en", 32'(bank_en), 32'(be));
    if (pr) chk("R1 p_loc", {p_bank, p_off}, {pa[15:14], pa[13:0]});
    if (dh) chk("R1 d_loc", {d_bank, d_off}, {da[15:14], da[13:0]});
    if (pe) chk("R8 p_cs", 32'(p_cs), 32'(exp_cs(pa)));
    if (de) chk("R8 d_cs", 32'(d_cs), 32'(exp_cs(da)));
    if (me) chk("R8 m_cs", 32'(m_cs), 32'(exp_cs(ma)));
    chk("R3 ovl_q", 32'(ovl_q), 32'(md));
    if (we && !sr) md = wd;
  endtask

  task automatic wr(logic v);
    step(0, 0, 0, 0, 0, 0, 1, v, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R5 ovl_q", 32'(ovl_q), 32'(v));
  endtask

  task automatic hw_reset();
    @(negedge clk); hw_rst_n = 0; ovl_we = 1; ovl_wdata = 1; #1;
    chk("R3 ovl_q in reset", 32'(ovl_q), 0);
    @(negedge clk); ovl_we = 0; hw_rst_n = 1; md = 0;
  endtask

  function automatic logic [22:0] raddr();
    int s = $urandom_range(0, 9);
    if (s < 4) return 23'h7F0000 | 23'($urandom_range(0, 16'hFFFF));
    if (s < 5) return 23'($urandom_range(0, 23'h02FFFF));
    return 23'($urandom_range(0, 23'h7FFFFF));
  endfunction

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    hw_rst_n = 1;
    chk("R3 reset state", 32'(ovl_q), 0);
    // R1 bank boundaries
    step(1, 23'h7F0000, 0, 0, 0, 0, 0, 0, 0);
    step(1, 23'h7F3FFF, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 23'h7FC000, 0, 0, 0, 0, 0);
    step(1, 23'h7EFFFF, 1, 23'h7FFFFF, 0, 0, 0, 0, 0);
    // R7 same bank / different banks
    step(1, 23'h7F4001, 1, 23'h7F7FFE, 0, 0, 0, 0, 0);
    step(1, 23'h7F8000, 1, 23'h7F0010, 0, 0, 0, 0, 0);
    // R6 DMA in window, mapped
    step(0, 0, 0, 0, 1, 23'h7F1234, 0, 0, 0);
    // R9 below external base
    step(1, 23'h027FFF, 1, 23'h000000, 1, 23'h010000, 0, 0, 0);
    // R8 CS boundaries
    step(1, 23'h028000, 1, 23'h1FFFFF, 1, 23'h200000, 0, 0, 0);
    step(1, 23'h5FFFFF, 1, 23'h600000, 1, 23'h6FFFFF, 0, 0, 0);
    step(1, 23'h700000, 1, 23'h77FFFF, 1, 23'h780000, 0, 0, 0);
    // R5 / R2 unmap
    wr(1);
    step(1, 23'h7F0000, 1, 23'h7F0000, 1, 23'h7FFFFF, 0, 0, 0);
    // R4 soft reset keeps bit, ignores write, quiets outputs
    step(1, 23'h7F0000, 1, 23'h100000, 1, 23'h7F0000, 1, 0, 1);
    step(1, 23'h7F0000, 0, 0, 1, 23'h7F0000, 0, 0, 0);
    chk("R4 ovl kept", 32'(ovl_q), 1);
    // R3 hard reset clears
    hw_reset();
    step(1, 23'h7F0000, 0, 0, 1, 23'h7F0000, 0, 0, 0);
    wr(1); wr(0);
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] ctl = 3'($urandom_range(0, 7));
      step(1'($urandom), raddr(), 1'($urandom), raddr(), 1'($urandom), raddr(),
           ($urandom_range(0, 15) == 0), 1'($urandom), ctl == 0);
      if ($urandom_range(0, 499) == 0) hw_reset();
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule